// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Serializer

This block answers a card reset on the serial data line. When the card reset input is high at a rising edge of the card clock, the block loads a 32-bit answer word and starts a fresh session. It then places one bit per clock pulse on an open-drain data line, beginning with the least significant bit of the lowest byte. Normal command traffic is sent most significant bit first, so this ordering is specific to the answer. The same reset edge sends a one-cycle pulse to the neighbouring access-control logic, which drops every verified password and any completed authentication.

All timing counts card-clock edges, which are sampled in the system clock domain. A new bit goes onto the line after each falling card-clock edge, so the host can sample it on the next rising edge. The host gives one reset pulse and then 32 more pulses to read the whole word. After the last bit the line is released, and later pulses send nothing until the next reset. A parameter selects the word's source: either a fixed constant whose bytes go out as 0x2C, 0xAA, 0x55, 0xA1, or a word presented on an input port that is captured at the reset edge.

Top module: `atr_serializer`

## Requirements
- R1: After system reset, `sda_pull_low`, `atr_driving` and `session_clear` are all 0.
- R2: A rising card-clock edge seen while `card_rst` is 1 raises `session_clear` for exactly one system-clock cycle, once per such edge.
- R3: After the reset edge, the falling edge of the n-th following card-clock pulse (n = 0 for the reset pulse itself) drives bit n of the captured word. Bit n is `atr_value[n]`, so byte 0 is `atr_value[7:0]` and goes out first, least significant bit first. `atr_driving` is 1 and `sda_pull_low` equals the inverse of that bit.
- R4: The line value changes only after a falling card-clock edge. It is stable throughout the high phase.
- R5: With the fixed-word variant selected, the emitted bytes are 0x2C, 0xAA, 0x55, 0xA1 in that order, whatever `atr_value` holds.
- R6: On the falling edge following the 32nd bit, `atr_driving` and `sda_pull_low` go to 0. Further pulses without a reset keep them at 0.
- R7: A reset edge during a transfer restarts it from bit 0 of byte 0, with the word newly captured.
- R8: Changes to `atr_value` after the reset edge do not alter the bits being sent.
- R9: Card-clock pulses with `card_rst` low that arrive when no transfer is running leave the line undriven.
- R10: `session_clear` stays 0 unless a rising card-clock edge coincides with `card_rst` high. A high `card_rst` with no rising edge does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Card clock, already synchronised to `clk` |
| card_rst | input | 1 | Card reset request, level sampled at card-clock rising edges |
| atr_value | input | NBITS | Answer word, byte 0 in bits 7:0 (port-word variant) |
| sda_pull_low | output | 1 | Pull the open-drain data line low |
| atr_driving | output | 1 | The block currently owns the data line |
| session_clear | output | 1 | One-cycle pulse that revokes password and authentication grants |

## Verification
If the bit counter or the shift register goes wrong, the line shows it at the next falling card-clock edge. That error may be a wrong bit, a byte sent most significant bit first, a transfer that ends one pulse early or late, or a restart that does not return to bit 0. The bench compares every bit of every transfer. A loss of hold between edges appears during the high phase, when the line is checked against the previous bit. A faulty clear pulse shows as a missing, duplicated or stray `session_clear` cycle, which is counted against the number of reset edges given.

// File: rtl/atr_pkg.sv
package atr_pkg;

    localparam int unsigned ATR_BITS_DEF = 32;

    // byte 0 in the low bits: sent first
    localparam logic [31:0] ATR_WORD_DEF = {8'hA1, 8'h55, 8'hAA, 8'h2C};

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
    } scl_ev_t;

    typedef enum logic {
        ATR_IDLE = 1'b0,
        ATR_SEND = 1'b1
    } atr_state_e;

    function automatic int unsigned cnt_width(input int unsigned nbits);
        return $clog2(nbits + 1);
    endfunction

endpackage

// File: rtl/atr_scl_edge.sv
module atr_scl_edge
    import atr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    card_rst,
    output scl_ev_t ev,
    output logic    clr_pulse
);

    logic scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q     <= 1'b0;
            clr_pulse <= 1'b0;
        end else begin
            scl_q     <= scl_in;
            clr_pulse <= ev.start;
        end
    end

    always_comb begin
        ev.rise  = scl_in & ~scl_q;
        ev.fall  = ~scl_in & scl_q;
        ev.start = ev.rise & card_rst;
    end

    AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> !clr_pulse); // R2

endmodule

// File: rtl/atr_sequencer.sv
module atr_sequencer
    import atr_pkg::*;
#(
    parameter int unsigned NBITS = ATR_BITS_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  scl_ev_t ev,
    output logic    seq_active,
    output logic    seq_done
);

    localparam int unsigned CW = cnt_width(NBITS);
    localparam logic [CW-1:0] LAST = CW'(NBITS);

    atr_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ATR_IDLE;
            cnt   <= '0;
        end else if (ev.start) begin
            state <= ATR_SEND;
            cnt   <= '0;
        end else if (state == ATR_SEND) begin
            if (ev.rise && cnt != LAST)
                cnt <= cnt + CW'(1);
            else if (ev.fall && cnt == LAST)
                state <= ATR_IDLE;
        end
    end

    always_comb begin
        seq_active = (state == ATR_SEND);
        seq_done   = (cnt == LAST);
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (cnt == '0 && state == ATR_SEND)); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R6

    AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && !ev.start && state == ATR_SEND && cnt != LAST)
        |=> cnt == $past(cnt) + CW'(1)); // R3

endmodule

// File: rtl/atr_shifter.sv
module atr_shifter
    import atr_pkg::*;
#(
    parameter int unsigned NBITS = ATR_BITS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  scl_ev_t          ev,
    input  logic [NBITS-1:0] word,
    input  logic             seq_active,
    input  logic             seq_done,
    output logic             line_drive,
    output logic             line_bit
);

    logic [NBITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (ev.start) begin
            sh <= word;
        end else if (ev.rise && seq_active && !seq_done) begin
            sh <= sh >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_drive <= 1'b0;
            line_bit   <= 1'b1;
        end else if (ev.fall) begin
            if (seq_active && !seq_done) begin
                line_drive <= 1'b1;
                line_bit   <= sh[0];
            end else begin
                line_drive <= 1'b0;
                line_bit   <= 1'b1;
            end
        end
    end

    AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (rst)
        !ev.fall |=> ($stable(line_drive) && $stable(line_bit))); // R4

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ev.fall && !seq_active) |=> !line_drive); // R9

endmodule

// File: rtl/atr_serializer.sv
module atr_serializer
    import atr_pkg::*;
#(
    parameter int unsigned      NBITS          = ATR_BITS_DEF,
    parameter logic [NBITS-1:0] ATR_WORD       = NBITS'(ATR_WORD_DEF),
    parameter bit               USE_FIXED_WORD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             card_rst,
    input  logic [NBITS-1:0] atr_value,
    output logic             sda_pull_low,
    output logic             atr_driving,
    output logic             session_clear
);

    scl_ev_t          ev;
    logic             seq_active;
    logic             seq_done;
    logic             line_drive;
    logic             line_bit;
    logic [NBITS-1:0] word_src;

    generate
        if (USE_FIXED_WORD) begin : g_fixed
            assign word_src = ATR_WORD;
        end else begin : g_port
            assign word_src = atr_value;
        end
    endgenerate

    atr_scl_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .card_rst  (card_rst),
        .ev        (ev),
        .clr_pulse (session_clear)
    );

    atr_sequencer #(.NBITS(NBITS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .seq_active (seq_active),
        .seq_done   (seq_done)
    );

    atr_shifter #(.NBITS(NBITS)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .word       (word_src),
        .seq_active (seq_active),
        .seq_done   (seq_done),
        .line_drive (line_drive),
        .line_bit   (line_bit)
    );

    assign atr_driving  = line_drive;
    assign sda_pull_low = line_drive & ~line_bit;

    AST_CLEAR_NEEDS_RESET: assert property (@(posedge clk) disable iff (rst)
        session_clear |-> $past(card_rst)); // R10

endmodule

// File: tb/test_atr_serializer.sv
module test_atr_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 32;
    localparam int HALF       = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl = 1'b0;
    logic          card_rst = 1'b0;
    logic [NB-1:0] atr_value = '0;
    logic          pull_a, drv_a, clr_a;
    logic          pull_f, drv_f, clr_f;

    int checks = 0;
    int errors = 0;
    int clr_cnt_a = 0;
    int clr_cnt_f = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atr_serializer i_atr_serializer (
        .clk(clk), .rst(rst), .scl_in(scl), .card_rst(card_rst),
        .atr_value(atr_value), .sda_pull_low(pull_a),
        .atr_driving(drv_a), .session_clear(clr_a)
    );

    atr_serializer #(.USE_FIXED_WORD(1'b1)) i_atr_serializer_fixed (
        .clk(clk), .rst(rst), .scl_in(scl), .card_rst(card_rst),
        .atr_value(atr_value), .sda_pull_low(pull_f),
        .atr_driving(drv_f), .session_clear(clr_f)
    );

    always @(negedge clk) begin
        if (clr_a) clr_cnt_a++;
        if (clr_f) clr_cnt_f++;
    end

    function automatic logic [NB-1:0] fixed_word();
        logic [7:0] b [4];
        b[0] = 8'h2C; b[1] = 8'hAA; b[2] = 8'h55; b[3] = 8'hA1;
        return {b[3], b[2], b[1], b[0]};
    endfunction

    function automatic logic exp_pull(input logic [NB-1:0] w, input int k);
        return ~w[k];
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_high(input bit rst_lvl);
        card_rst = rst_lvl;
        wait_clk(1);
        scl = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic scl_low();
        scl = 1'b0;
        wait_clk(1);
        card_rst = 1'b0;
        wait_clk(HALF - 1);
    endtask

    task automatic start_seq(input logic [NB-1:0] w);
        int ca, cf;
        ca = clr_cnt_a; cf = clr_cnt_f;
        atr_value = w;
        scl_high(1'b1);
        scl_low();
        check(clr_cnt_a == ca + 1, "R2 clear pulse port", clr_cnt_a - ca, 1);
        check(clr_cnt_f == cf + 1, "R2 clear pulse fixed", clr_cnt_f - cf, 1);
        check(drv_a && pull_a == exp_pull(w, 0), "R3 bit0",
              {drv_a, pull_a}, {1'b1, exp_pull(w, 0)});
        check(drv_f && pull_f == exp_pull(fixed_word(), 0), "R5 bit0",
              {drv_f, pull_f}, {1'b1, exp_pull(fixed_word(), 0)});
    endtask

    task automatic send_bits(input logic [NB-1:0] w, input int first,
                             input int last, input int flip_at);
        for (int k = first; k <= last; k++) begin
            if (k == flip_at) atr_value = ~atr_value ^ NB'($urandom());
            scl_high(1'b0);
            check(pull_a == exp_pull(w, k - 1), "R4 hold in high phase",
                  pull_a, exp_pull(w, k - 1));
            scl_low();
            check(drv_a && pull_a == exp_pull(w, k),
                  (flip_at >= 0) ? "R8 captured bit" : "R3 bit",
                  {drv_a, pull_a}, {1'b1, exp_pull(w, k)});
            check(drv_f && pull_f == exp_pull(fixed_word(), k), "R5 fixed bit",
                  {drv_f, pull_f}, {1'b1, exp_pull(fixed_word(), k)});
        end
    endtask

    task automatic expect_release();
        for (int p = 0; p < 3; p++) begin
            scl_high(1'b0);
            scl_low();
            check(!drv_a && !pull_a, "R6 released port", {drv_a, pull_a}, 0);
            check(!drv_f && !pull_f, "R6 released fixed", {drv_f, pull_f}, 0);
        end
    endtask

    initial begin
        logic [NB-1:0] w;
        int ca;
        void'($urandom(32'd1597));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1
        check(!pull_a && !drv_a && !clr_a, "R1 reset state",
              {pull_a, drv_a, clr_a}, 0);

        // R9 R10: pulses with no reset
        for (int p = 0; p < 3; p++) begin
            scl_high(1'b0);
            scl_low();
            check(!drv_a && !pull_a, "R9 idle pulses", {drv_a, pull_a}, 0);
        end
        card_rst = 1'b1;
        wait_clk(6);
        card_rst = 1'b0;
        wait_clk(2);
        check(clr_cnt_a == 0, "R10 no clear without edge", clr_cnt_a, 0);

        // default-looking word on port, full transfer
        w = fixed_word();
        start_seq(w);
        send_bits(w, 1, NB - 1, -1);
        expect_release();

        // R8: port changes mid transfer
        w = NB'($urandom());
        start_seq(w);
        send_bits(w, 1, NB - 1, 10);
        expect_release();

        // R7: restart part way
        w = NB'($urandom());
        start_seq(w);
        send_bits(w, 1, 12, -1);
        w = NB'($urandom());
        start_seq(w);
        send_bits(w, 1, NB - 1, -1);
        expect_release();

        // corner words and random words
        for (int i = 0; i < 7; i++) begin
            case (i)
                0: w = '0;
                1: w = '1;
                2: w = 32'h8000_0001;
                default: w = NB'($urandom());
            endcase
            start_seq(w);
            send_bits(w, 1, NB - 1, -1);
            expect_release();
        end

        ca = clr_cnt_a;
        for (int p = 0; p < 2; p++) begin
            scl_high(1'b0);
            scl_low();
        end
        check(clr_cnt_a == ca, "R10 no clear on plain pulses", clr_cnt_a - ca, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule